// File: doc/BRIEF.md
# Balanced Serial Frame Encoder

This block turns a stream of parallel words into a DC-balanced serial line. Each frame holds a data field of 16 or 20 bits with a 4-bit control field above it. The control field names the frame kind and always carries a fixed level change that a receiver can lock onto, so no separate sync words are needed. For every frame the block chooses one of three kinds. A control word carries a shortened payload. A data word carries the full payload. A fill frame keeps the line alive when the source has nothing to send, and it comes in two fixed patterns that a link partner can use for startup handshaking.

The block keeps a signed running disparity. Before a frame leaves, it may invert the whole frame if sending it unchanged would push the line further from an equal count of ones and zeros. A flag input either travels as one extra payload bit or is replaced by an internal first/second segment marker for words sent in two halves. One clock drives everything at the bit rate. The block pulses `take` in the cycle in which it samples its inputs, and a new frame starts every 20 or 24 cycles.

Top module: `balanced_frame_enc`

## Requirements
- R1: In narrow mode (`wide_mode`=0) the frame is 20 bits: data in bits 15..0, control field in 19..16, and bits 23..20 of `frame_word` read zero. In wide mode the frame is 24 bits: data in 19..0, control in 23..20. `take` pulses once per frame, 20 or 24 cycles apart.
- R2: If `cav_n` is low, the frame is a control word whatever `dav_n` is. Its data field holds only the low 14 (narrow) or 18 (wide) bits of `din`, the bits above are zero, and its control code is 1011.
- R3: If `cav_n` is high and `dav_n` is low, the frame is a data word. It carries all 16 or 20 bits of `din`, and its control code is 110m, where m is the inverse of the segment marker.
- R4: If both strobes are high, the frame is a fill frame with control code 1010. With `fill_sel`=0 its data field is 0xFF00 (narrow) or 0xFFC00 (wide). With `fill_sel`=1 it is 0xF0F0 (narrow) or 0xF83E0 (wide).
- R5: In every transmitted frame, inverted or not, control bits 2 and 1 differ.
- R6: Let the sign be ones minus zeros of the uninverted frame. The frame is inverted only when the accumulator and the sign are both nonzero and of the same polarity. The accumulator then adds the sign of the frame as sent. `frame_inv` marks inverted frames, and control bit 3 as sent equals the inverse of `frame_inv`.
- R7: With `flag_as_data`=1, the marker of a data word is `flag_in`.
- R8: With `flag_as_data`=0, `flag_in` has no effect. The marker is 0 on the first data word after reset or after any non-data frame, and it alternates on each following data word.
- R9: `ser_out` sends the frame least significant bit first. Bit 0 appears in the cycle after `take`, and the last bit appears in the cycle of the next `take`.
- R10: The asynchronous active-low reset clears the disparity and the marker. While the reset is active, and until two clock edges after its release, `take`, `frame_word`, `frame_inv` and `ser_out` are low. The first `take` follows the second rising edge after release.
- R11: `wide_mode` is sampled with the other inputs at `take`. A change of mode affects only frames that start after it, and a frame already in flight keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode | input | 1 | 0: 16-bit data field, 1: 20-bit data field |
| flag_as_data | input | 1 | 1: `flag_in` is the marker; 0: internal segment marker |
| dav_n | input | 1 | Data available, active low |
| cav_n | input | 1 | Control word available, active low |
| fill_sel | input | 1 | Fill pattern select |
| flag_in | input | 1 | Extra payload bit |
| din | input | 20 | Parallel payload |
| take | output | 1 | Inputs are sampled in this cycle |
| frame_word | output | 24 | Frame currently being sent, after inversion |
| frame_inv | output | 1 | Current frame was inverted |
| ser_out | output | 1 | Serial line |

## Verification
The inversion branch is the hardest case to reach from the ports. It needs the accumulator to be nonzero and to agree in polarity with the next frame, and fill frames carry zero sign, so they never set it up. The stimulus therefore sends back-to-back strongly unbalanced data words: all ones for the positive side and all zeros for the negative side, in both widths. It also issues a reset while the accumulator is nonzero, then repeats the pair to show the history was cleared. A long run of random frames follows, with mixed kinds and widths, and is checked against a bench-side disparity model.

// File: rtl/fse_pkg.sv
package fse_pkg;
  localparam int CTL_W = 4;

  typedef enum logic [1:0] {
    KIND_FILL = 2'd0,
    KIND_DATA = 2'd1,
    KIND_CTRL = 2'd2
  } frame_kind_e;

  // Control codes before inversion; bit 3 high marks "not inverted",
  // bits 2 and 1 always differ (guaranteed level change).
  localparam logic [CTL_W-1:0] CODE_DATA_M0 = 4'b1101;
  localparam logic [CTL_W-1:0] CODE_DATA_M1 = 4'b1100;
  localparam logic [CTL_W-1:0] CODE_CTRL    = 4'b1011;
  localparam logic [CTL_W-1:0] CODE_FILL    = 4'b1010;
endpackage

// File: rtl/fse_rst_sync.sv
module fse_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic stage_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      hold_q  <= stage_q;
    end
  end

  assign rst_s_n = hold_q;
endmodule

// File: rtl/fse_frame_build.sv
module fse_frame_build
  import fse_pkg::*;
#(
  parameter  int DW_N = 16,
  parameter  int DW_W = 20,
  localparam int FW   = DW_W + CTL_W
) (
  input  logic            wide,
  input  logic            flag_as_data,
  input  logic            dav_n,
  input  logic            cav_n,
  input  logic            fill_sel,
  input  logic            flag,
  input  logic            seg_q,
  input  logic [DW_W-1:0] din,
  output frame_kind_e     kind,
  output logic [FW-1:0]   raw
);
  localparam logic [DW_N-1:0] CMASK_N = {2'b00, {(DW_N-2){1'b1}}};
  localparam logic [DW_W-1:0] CMASK_W = {2'b00, {(DW_W-2){1'b1}}};

  // Fill patterns: type 0 = upper half ones, type 1 = alternating quarter groups
  logic [DW_N-1:0] fill0_n, fill1_n;
  logic [DW_W-1:0] fill0_w, fill1_w;

  for (genvar i = 0; i < DW_N; i++) begin : g_fill_n
    assign fill0_n[i] = (i >= DW_N / 2);
    assign fill1_n[i] = (((i / (DW_N / 4)) % 2) == 1);
  end
  for (genvar j = 0; j < DW_W; j++) begin : g_fill_w
    assign fill0_w[j] = (j >= DW_W / 2);
    assign fill1_w[j] = (((j / (DW_W / 4)) % 2) == 1);
  end

  logic             marker;
  logic [CTL_W-1:0] ctl;
  logic [DW_N-1:0]  data_n;
  logic [DW_W-1:0]  data_w;

  always_comb begin
    if (!cav_n)      kind = KIND_CTRL;
    else if (!dav_n) kind = KIND_DATA;
    else             kind = KIND_FILL;

    marker = flag_as_data ? flag : seg_q;

    unique case (kind)
      KIND_CTRL: begin
        ctl    = CODE_CTRL;
        data_n = din[DW_N-1:0] & CMASK_N;
        data_w = din & CMASK_W;
      end
      KIND_DATA: begin
        ctl    = marker ? CODE_DATA_M1 : CODE_DATA_M0;
        data_n = din[DW_N-1:0];
        data_w = din;
      end
      default: begin
        ctl    = CODE_FILL;
        data_n = fill_sel ? fill1_n : fill0_n;
        data_w = fill_sel ? fill1_w : fill0_w;
      end
    endcase

    if (wide) raw = {ctl, data_w};
    else      raw = {{(FW-DW_N-CTL_W){1'b0}}, ctl, data_n};
  end
endmodule

// File: rtl/fse_disparity.sv
module fse_disparity
  import fse_pkg::*;
#(
  parameter  int DW_N  = 16,
  parameter  int DW_W  = 20,
  parameter  int ACC_W = 8,
  localparam int FW    = DW_W + CTL_W,
  localparam int FL_N  = DW_N + CTL_W,
  localparam int PC_W  = $clog2(FW + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    wide,
  input  logic [FW-1:0]           raw,
  output logic                    invert,
  output logic [FW-1:0]           sent,
  output logic signed [ACC_W-1:0] acc_q
);
  localparam logic [FW-1:0] MASK_N = {{(FW-FL_N){1'b0}}, {FL_N{1'b1}}};

  logic [PC_W-1:0]         pc;
  logic signed [ACC_W-1:0] fl_s;
  logic signed [ACC_W-1:0] sgn;
  logic signed [ACC_W-1:0] step;
  logic signed [ACC_W-1:0] acc_d;
  logic [FW-1:0]           mask;

  always_comb begin
    pc = '0;
    for (int i = 0; i < FW; i++) pc = pc + PC_W'(raw[i]);
  end

  always_comb begin
    fl_s   = wide ? ACC_W'(FW) : ACC_W'(FL_N);
    sgn    = $signed({{(ACC_W-PC_W-1){1'b0}}, pc, 1'b0}) - fl_s;
    invert = (acc_q != '0) && (sgn != '0) && (acc_q[ACC_W-1] == sgn[ACC_W-1]);
    mask   = wide ? {FW{1'b1}} : MASK_N;
    sent   = invert ? (raw ^ mask) : raw;
    step   = invert ? -sgn : sgn;
    acc_d  = acc_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (load) acc_q <= acc_d;
  end
endmodule

// File: rtl/fse_serializer.sv
module fse_serializer
  import fse_pkg::*;
#(
  parameter  int DW_N = 16,
  parameter  int DW_W = 20,
  localparam int FW   = DW_W + CTL_W,
  localparam int FL_N = DW_N + CTL_W,
  localparam int CW   = $clog2(FW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide,
  input  logic [FW-1:0] frame_in,
  output logic          take,
  output logic          ser_out
);
  logic [CW-1:0] cnt_q, cnt_d, last;
  logic          mode_q, mode_d;
  logic [FW-1:0] sh_q, sh_d;

  assign take    = rst_n && (cnt_q == '0);
  assign ser_out = sh_q[0];

  always_comb begin
    last   = mode_q ? CW'(FW - 1) : CW'(FL_N - 1);
    cnt_d  = (cnt_q == last) ? '0 : cnt_q + CW'(1);
    mode_d = take ? wide : mode_q;
    sh_d   = take ? frame_in : (sh_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mode_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
      sh_q   <= sh_d;
    end
  end
endmodule

// File: rtl/balanced_frame_enc.sv
module balanced_frame_enc
  import fse_pkg::*;
#(
  parameter int DW_N  = 16,
  parameter int DW_W  = 20,
  parameter int ACC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wide_mode,
  input  logic                  flag_as_data,
  input  logic                  dav_n,
  input  logic                  cav_n,
  input  logic                  fill_sel,
  input  logic                  flag_in,
  input  logic [DW_W-1:0]       din,
  output logic                  take,
  output logic [DW_W+CTL_W-1:0] frame_word,
  output logic                  frame_inv,
  output logic                  ser_out
);
  localparam int FW = DW_W + CTL_W;

  logic                    rst_s_n;
  frame_kind_e             kind;
  logic [FW-1:0]           raw, sent;
  logic                    invert;
  logic signed [ACC_W-1:0] acc_q;
  logic                    seg_q, seg_d;
  logic [FW-1:0]           frame_q, frame_d;
  logic                    inv_q, inv_d;

  fse_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  fse_frame_build #(.DW_N(DW_N), .DW_W(DW_W)) u_build (
    .wide         (wide_mode),
    .flag_as_data (flag_as_data),
    .dav_n        (dav_n),
    .cav_n        (cav_n),
    .fill_sel     (fill_sel),
    .flag         (flag_in),
    .seg_q        (seg_q),
    .din          (din),
    .kind         (kind),
    .raw          (raw)
  );

  fse_disparity #(.DW_N(DW_N), .DW_W(DW_W), .ACC_W(ACC_W)) u_disp (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load   (take),
    .wide   (wide_mode),
    .raw    (raw),
    .invert (invert),
    .sent   (sent),
    .acc_q  (acc_q)
  );

  fse_serializer #(.DW_N(DW_N), .DW_W(DW_W)) u_ser (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wide     (wide_mode),
    .frame_in (sent),
    .take     (take),
    .ser_out  (ser_out)
  );

  always_comb begin
    seg_d   = seg_q;
    frame_d = frame_q;
    inv_d   = inv_q;
    if (take) begin
      seg_d   = (kind == KIND_DATA) && !flag_as_data && !seg_q;
      frame_d = sent;
      inv_d   = invert;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      seg_q   <= 1'b0;
      frame_q <= '0;
      inv_q   <= 1'b0;
    end else begin
      seg_q   <= seg_d;
      frame_q <= frame_d;
      inv_q   <= inv_d;
    end
  end

  assign frame_word = frame_q;
  assign frame_inv  = inv_q;
endmodule

// File: rtl/fse_checker.sv
module fse_checker #(
  parameter int DW_N  = 16,
  parameter int DW_W  = 20,
  parameter int ACC_W = 8
) (
  input logic                    clk,
  input logic                    rst_s_n,
  input logic                    take,
  input logic                    wide_mode,
  input logic [DW_W+3:0]         frame_word,
  input logic                    frame_inv,
  input logic                    ser_out,
  input logic signed [ACC_W-1:0] acc
);
  localparam logic signed [ACC_W-1:0] BOUND = ACC_W'(DW_W + 4);

  a_r1_take_gap: assert property (@(posedge clk) disable iff (!rst_s_n)
    take |=> !take);

  a_r1_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (take && !wide_mode) |=> (frame_word[DW_W+3:DW_N+4] == '0));

  a_r5_master_edge: assert property (@(posedge clk) disable iff (!rst_s_n)
    take |=> ($past(wide_mode) ? (frame_word[DW_W+2] != frame_word[DW_W+1])
                               : (frame_word[DW_N+2] != frame_word[DW_N+1])));

  a_r6_polarity_tag: assert property (@(posedge clk) disable iff (!rst_s_n)
    take |=> ($past(wide_mode) ? (frame_word[DW_W+3] != frame_inv)
                               : (frame_word[DW_N+3] != frame_inv)));

  a_r6_acc_bounded: assert property (@(posedge clk) disable iff (!rst_s_n)
    (acc <= BOUND) && (acc >= -BOUND));

  a_r9_first_bit: assert property (@(posedge clk) disable iff (!rst_s_n)
    take |=> (ser_out == frame_word[0]));

  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_s_n |-> (frame_word == '0 && !frame_inv && !take && !ser_out));
endmodule

bind balanced_frame_enc fse_checker #(.DW_N(DW_N), .DW_W(DW_W), .ACC_W(ACC_W)) u_chk (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .take       (take),
  .wide_mode  (wide_mode),
  .frame_word (frame_word),
  .frame_inv  (frame_inv),
  .ser_out    (ser_out),
  .acc        (acc_q)
);

// File: tb/sim_balanced_frame_enc.sv
module sim_balanced_frame_enc;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT_CYCLES = 150000;

  logic        clk;
  logic        rst_n;
  logic        wide_mode, flag_as_data, dav_n, cav_n, fill_sel, flag_in;
  logic [19:0] din;
  logic        take;
  logic [23:0] frame_word;
  logic        frame_inv;
  logic        ser_out;

  balanced_frame_enc u0 (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .flag_as_data(flag_as_data),
    .dav_n(dav_n), .cav_n(cav_n), .fill_sel(fill_sel), .flag_in(flag_in), .din(din),
    .take(take), .frame_word(frame_word), .frame_inv(frame_inv), .ser_out(ser_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [23:0] word;
    logic        inv;
    int          fl;
    string       req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  int   acc_m = 0;
  bit   seg_m = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: waits for take at a falling edge, applies inputs, pushes expected frame
  task automatic send(input bit cn, input bit dn, input bit fs, input bit fl,
                      input bit fsel, input bit wd, input logic [19:0] d, input string req);
    int dw, flen, pc, s;
    logic [19:0] data;
    logic [3:0]  ctl;
    logic [23:0] raw, sent;
    bit inv, mk;
    exp_t e;
    while (!take) @(negedge clk);
    cav_n = cn; dav_n = dn; fill_sel = fs; flag_in = fl;
    flag_as_data = fsel; wide_mode = wd; din = d;
    dw = wd ? 20 : 16;
    flen = dw + 4;
    if (!cn) begin
      ctl = 4'b1011; data = d & 20'((32'h1 << (dw - 2)) - 1); seg_m = 0;
    end else if (!dn) begin
      mk = fsel ? fl : seg_m;
      ctl = {3'b110, ~mk};
      data = d & 20'((32'h1 << dw) - 1);
      seg_m = fsel ? 1'b0 : ~seg_m;
    end else begin
      ctl = 4'b1010;
      if (wd) data = fs ? 20'hF83E0 : 20'hFFC00;
      else    data = fs ? 20'h0F0F0 : 20'h0FF00;
      seg_m = 0;
    end
    raw = (24'(ctl) << dw) | 24'(data);
    pc = $countones(raw);
    s = 2 * pc - flen;
    inv = (acc_m != 0) && (s != 0) && ((acc_m > 0) == (s > 0));
    sent = inv ? (~raw & 24'((32'h1 << flen) - 1)) : raw;
    acc_m += inv ? -s : s;
    e.word = sent; e.inv = inv; e.fl = flen; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compares each loaded frame and every serial bit
  bit          took_prev = 0;
  bit          have_cur = 0;
  logic [23:0] cur;
  int          cur_fl = 0;
  int          idx = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      took_prev = 0;
      have_cur = 0;
    end else begin
      if (took_prev) begin
        if (have_cur) check(idx == cur_fl, "R1", "bits per frame", idx, cur_fl);
        if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check(frame_word == e.word, e.req, "frame word", {8'b0, frame_word}, {8'b0, e.word});
          check(frame_inv == e.inv, "R6", "inversion flag", frame_inv, e.inv);
          if (e.fl == 24) check(frame_word[22] != frame_word[21], "R5", "level change", frame_word[23:20], 0);
          else            check(frame_word[18] != frame_word[17], "R5", "level change", frame_word[19:16], 0);
          cur = e.word; cur_fl = e.fl; idx = 0; have_cur = 1;
        end else begin
          have_cur = 0;
        end
      end
      if (have_cur && idx < cur_fl) begin
        check(ser_out == cur[idx], "R9", "serial bit", ser_out, cur[idx]);
        idx++;
      end
      took_prev = take;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (TIMEOUT_CYCLES) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic reset_phase();
    rst_n = 1'b0;
    acc_m = 0; seg_m = 0; q.delete();
    repeat (3) @(negedge clk);
    check(frame_word == 24'h0, "R10", "reset frame word", {8'b0, frame_word}, 0);
    check(!frame_inv && !ser_out, "R10", "reset inv/serial", {frame_inv, ser_out}, 0);
    check(!take, "R10", "reset take", take, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!take, "R10", "take one edge after release", take, 0);
    @(negedge clk);
    check(take, "R10", "take two edges after release", take, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    wide_mode = 0; flag_as_data = 1; dav_n = 1; cav_n = 1; fill_sel = 0; flag_in = 0; din = '0;
    reset_phase();

    // narrow mode basics and positive-side inversion
    send(1, 0, 0, 0, 1, 0, 20'h0FFFF, "R3");
    send(1, 0, 0, 0, 1, 0, 20'h0FFFF, "R6");
    send(1, 1, 0, 0, 1, 0, 20'h12345, "R4");
    send(1, 1, 1, 0, 1, 0, 20'h12345, "R4");
    send(0, 1, 0, 0, 1, 0, 20'hFFFFF, "R2");
    send(0, 0, 0, 0, 1, 0, 20'hABCDE, "R2");
    // negative-side inversion
    send(1, 0, 0, 0, 1, 0, 20'h00000, "R6");
    send(1, 0, 0, 0, 1, 0, 20'h00000, "R6");
    // flag as payload
    send(1, 0, 0, 1, 1, 0, 20'h05A5A, "R7");
    send(1, 0, 0, 0, 1, 0, 20'h05A5A, "R7");
    // segment marker, flag ignored
    send(1, 0, 0, 1, 0, 0, 20'h01234, "R8");
    send(1, 0, 0, 0, 0, 0, 20'h01234, "R8");
    send(1, 0, 0, 1, 0, 0, 20'h01234, "R8");
    send(1, 1, 0, 1, 0, 0, 20'h00000, "R8");
    send(1, 0, 0, 1, 0, 0, 20'h04321, "R8");
    // wide mode
    send(1, 0, 0, 0, 1, 1, 20'hFFFFF, "R11");
    send(1, 0, 0, 0, 1, 1, 20'hFFFFF, "R6");
    send(1, 1, 0, 0, 1, 1, 20'h00000, "R4");
    send(1, 1, 1, 0, 1, 1, 20'h00000, "R4");
    send(0, 1, 0, 0, 1, 1, 20'hFFFFF, "R2");
    send(1, 0, 0, 1, 1, 1, 20'h00000, "R7");
    send(1, 0, 0, 0, 1, 0, 20'h0BEEF, "R11");
    send(1, 0, 0, 0, 1, 1, 20'hC0FFE, "R11");
    send(1, 0, 0, 0, 1, 0, 20'h0FFFF, "R1");

    // reset with nonzero history
    @(negedge clk);
    reset_phase();
    send(1, 0, 0, 0, 1, 0, 20'h0FFFF, "R10");
    send(1, 0, 0, 0, 1, 0, 20'h0FFFF, "R10");

    for (int k = 0; k < 60; k++) begin
      bit cn, dn;
      int r;
      r = int'($urandom_range(0, 7));
      cn = (r == 0);
      dn = (r < 5) ? 1'b0 : 1'b1;
      send(cn, dn, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           20'($urandom), "R3");
    end

    repeat (30) @(negedge clk);
    check(q.size() == 0, "R1", "all frames produced", q.size(), 0);
    summary();
    $finish;
  end
endmodule